// File: doc/BRIEF.md
# Iterative Radix-4 64-Point FFT Engine

This block computes a 64-point complex discrete Fourier transform, or its inverse, on one shared four-input butterfly. A frame of 64 complex samples is streamed in one per valid cycle and placed into a working memory in base-4 digit-reversed order. A start strobe then launches three in-place passes of 16 butterflies each. Each butterfly multiplies three of its four operands by twiddle factors taken from an internal quarter-wave cosine table and then combines all four.

When the last pass is over, the 64 results stream out in natural frequency (or time) order on consecutive cycles, and a one-cycle done pulse follows them. The inverse transform uses the same schedule with conjugated twiddles and a fixed scaling by 1/64. Internally the data carries fractional guard bits. Results are rounded to nearest and clamped to the output width.

Top module: `fft4_engine`

## Requirements
- R1: In forward mode (inverse=0) the 64 outputs are X[k] = sum over n of x[n]·e^(-j2πnk/64), each rounded to the nearest integer and within 1 LSB of that value. They appear on 64 consecutive out_valid cycles in order k = 0..63.
- R2: In inverse mode (inverse=1) the outputs are (1/64)·sum over n of x[n]·e^(+j2πnk/64), rounded to nearest and within 1 LSB. They are delivered in the same order and burst form as in R1.
- R3: in_re and in_im are 4-bit two's complement. The i-th sample accepted with in_valid since the previous start is x[i], for i = 0..63.
- R4: Each output component is 8-bit two's complement. A result above 127 reads 127 and a result below -128 reads -128.
- R5: done is high for exactly one cycle, the cycle right after the last out_valid of a frame. Every frame that has been started reaches done.
- R6: Once a start is accepted, further start pulses and in_valid samples are ignored until the frame's results have been issued. The frame's results do not change.
- R7: After reset, out_valid and done are low and stay low until a frame has been started.
- R8: The inverse input is sampled only in the cycle start is accepted. Changes to it while the transform runs have no effect.
- R9: A frame whose only nonzero sample is x[0] = v produces X[k] = v exactly for every k in forward mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe while idle |
| in_re | input | 4 | Sample real part, signed |
| in_im | input | 4 | Sample imaginary part, signed |
| start | input | 1 | Begin the transform of the loaded frame |
| inverse | input | 1 | 1 selects the inverse transform, sampled at start |
| out_valid | output | 1 | Result strobe |
| out_re | output | 8 | Result real part, signed |
| out_im | output | 8 | Result imaginary part, signed |
| done | output | 1 | One-cycle pulse after the last result |

## Verification
The embedded properties assume that exactly 64 samples are presented before each start. They also assume that start arrives only once the previous frame's done has been seen, so that each output burst belongs to one frame and its done. The bench always loads a full frame and waits for done before loading the next. Start pulses and samples are deliberately thrown at the block only while it is computing, where R6 says they are ignored. The input ports are only 4 bits wide, so every sample is within range by construction. Test frames include the extreme values 7 and -8 to drive the saturation cases.

// File: rtl/fft4_pkg.sv
package fft4_pkg;
  // transform geometry: 4^LOG4N points (twiddle table below is sized for 64)
  localparam int LOG4N   = 3;
  localparam int NPTS    = 4 ** LOG4N;
  localparam int AW      = 2 * LOG4N;
  localparam int TW_W    = 16;
  localparam int TW_FRAC = 14;

  // reverse the order of the base-4 digits of an address
  function automatic logic [AW-1:0] digit_rev(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    for (int i = 0; i < LOG4N; i++) r[2*i +: 2] = a[AW-2-2*i +: 2];
    return r;
  endfunction

  // cos(2*pi*i/64) in Q2.14 for i = 0..16
  function automatic logic signed [TW_W-1:0] qcos(input logic [4:0] i);
    case (i)
      5'd0:  return 16'sd16384;
      5'd1:  return 16'sd16305;
      5'd2:  return 16'sd16069;
      5'd3:  return 16'sd15679;
      5'd4:  return 16'sd15137;
      5'd5:  return 16'sd14449;
      5'd6:  return 16'sd13623;
      5'd7:  return 16'sd12665;
      5'd8:  return 16'sd11585;
      5'd9:  return 16'sd10394;
      5'd10: return 16'sd9102;
      5'd11: return 16'sd7723;
      5'd12: return 16'sd6270;
      5'd13: return 16'sd4756;
      5'd14: return 16'sd3196;
      5'd15: return 16'sd1606;
      default: return 16'sd0;
    endcase
  endfunction
endpackage

// File: rtl/fft4_ram.sv
module fft4_ram #(
  parameter int W  = 40,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/fft4_twiddle.sv
module fft4_twiddle import fft4_pkg::*; (
  input  logic [AW-1:0]          exp_i,
  input  logic                   inv_i,
  output logic signed [TW_W-1:0] w_re,
  output logic signed [TW_W-1:0] w_im
);
  logic [1:0] quad;
  logic [4:0] r;
  logic signed [TW_W-1:0] cr, cc, c, s;

  always_comb begin
    quad = exp_i[AW-1 -: 2];
    r    = {1'b0, exp_i[AW-3:0]};
    cr   = qcos(r);
    cc   = qcos(5'd16 - r);
    case (quad)
      2'd0:    begin c = cr;  s = cc;  end
      2'd1:    begin c = -cc; s = cr;  end
      2'd2:    begin c = -cr; s = -cc; end
      default: begin c = cc;  s = -cr; end
    endcase
    w_re = c;
    w_im = inv_i ? s : -s;
  end
endmodule

// File: rtl/fft4_bfly.sv
module fft4_bfly import fft4_pkg::*; #(
  parameter int DW = 20
) (
  input  logic [3:0][DW-1:0]   x_re,
  input  logic [3:0][DW-1:0]   x_im,
  input  logic [2:0][TW_W-1:0] w_re,
  input  logic [2:0][TW_W-1:0] w_im,
  input  logic                 inv_i,
  output logic [3:0][DW-1:0]   y_re,
  output logic [3:0][DW-1:0]   y_im
);
  localparam int PW = DW + TW_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (TW_FRAC - 1);
  localparam logic signed [PW-1:0] HI   = (PW'(1) << (DW - 1)) - PW'(1);
  localparam logic signed [PW-1:0] LO   = -HI - PW'(1);

  function automatic logic [DW-1:0] rnd_sat(input logic signed [PW-1:0] p);
    logic signed [PW-1:0] t;
    t = (p + HALF) >>> TW_FRAC;
    if (t > HI) t = HI;
    else if (t < LO) t = LO;
    return t[DW-1:0];
  endfunction

  logic [3:0][DW-1:0] t_re, t_im;
  logic [DW-1:0] s1r, s1i, s3r, s3i;

  assign t_re[0] = x_re[0];
  assign t_im[0] = x_im[0];

  for (genvar m = 1; m < 4; m++) begin : g_mul
    logic signed [PW-1:0] pr, pi;
    assign pr = $signed(x_re[m]) * $signed(w_re[m-1]) - $signed(x_im[m]) * $signed(w_im[m-1]);
    assign pi = $signed(x_re[m]) * $signed(w_im[m-1]) + $signed(x_im[m]) * $signed(w_re[m-1]);
    assign t_re[m] = rnd_sat(pr);
    assign t_im[m] = rnd_sat(pi);
  end

  always_comb begin
    // forward kernel rows 1 and 3; the inverse swaps them
    s1r = t_re[0] + t_im[1] - t_re[2] - t_im[3];
    s1i = t_im[0] - t_re[1] - t_im[2] + t_re[3];
    s3r = t_re[0] - t_im[1] - t_re[2] + t_im[3];
    s3i = t_im[0] + t_re[1] - t_im[2] - t_re[3];
    y_re[0] = t_re[0] + t_re[1] + t_re[2] + t_re[3];
    y_im[0] = t_im[0] + t_im[1] + t_im[2] + t_im[3];
    y_re[2] = t_re[0] - t_re[1] + t_re[2] - t_re[3];
    y_im[2] = t_im[0] - t_im[1] + t_im[2] - t_im[3];
    y_re[1] = inv_i ? s3r : s1r;
    y_im[1] = inv_i ? s3i : s1i;
    y_re[3] = inv_i ? s1r : s3r;
    y_im[3] = inv_i ? s1i : s3i;
  end
endmodule

// File: rtl/fft4_engine.sv
module fft4_engine import fft4_pkg::*; #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 8,
  parameter int DW    = 20,
  parameter int FRAC  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_re,
  input  logic signed [IN_W-1:0]  in_im,
  input  logic                    start,
  input  logic                    inverse,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_re,
  output logic signed [OUT_W-1:0] out_im,
  output logic                    done
);
  localparam int BW = AW - 2;
  localparam int SW = $clog2(LOG4N);
  localparam int SH_F = FRAC;
  localparam int SH_I = FRAC + AW;
  localparam logic signed [DW:0] HALF_F = (DW+1)'(1) << (SH_F - 1);
  localparam logic signed [DW:0] HALF_I = (DW+1)'(1) << (SH_I - 1);
  localparam logic signed [DW:0] OMAX   = ((DW+1)'(1) << (OUT_W - 1)) - (DW+1)'(1);
  localparam logic signed [DW:0] OMIN   = -OMAX - (DW+1)'(1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_OUT} st_t;
  st_t state;

  logic [AW-1:0] load_cnt, oc, j_idx, grp, base, tw_e, bf_addr;
  logic [SW-1:0] stg;
  logic [BW-1:0] bf;
  logic [3:0]    ph;
  logic [1:0]    m_sel;
  logic          inv_r;
  int            sh;
  logic [3:0][DW-1:0]   a_re, a_im, r_re, r_im, b_re, b_im;
  logic [2:0][TW_W-1:0] w_re, w_im;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [2*DW-1:0] ram_wd, ram_q;
  logic          v1, l1, l2, inv1;

  function automatic logic signed [OUT_W-1:0] to_out(input logic [DW-1:0] v, input logic iv);
    logic signed [DW:0] t;
    t = $signed({v[DW-1], v}) + (iv ? HALF_I : HALF_F);
    t = iv ? (t >>> SH_I) : (t >>> SH_F);
    if (t > OMAX) t = OMAX;
    else if (t < OMIN) t = OMIN;
    return t[OUT_W-1:0];
  endfunction

  // butterfly addressing: span 4^stg, twiddle step 16/4^stg
  always_comb begin
    sh      = 2 * int'(stg);
    j_idx   = AW'(bf) & ((AW'(1) << sh) - AW'(1));
    grp     = AW'(bf) >> sh;
    base    = (grp << (sh + 2)) | j_idx;
    tw_e    = j_idx << (AW - 2 - sh);
    m_sel   = (ph >= 4'd6) ? 2'(ph - 4'd6) : ph[1:0];
    bf_addr = base | (AW'(m_sel) << sh);
  end

  always_comb begin
    ram_we   = 1'b0;
    ram_addr = digit_rev(load_cnt);
    ram_wd   = {{(DW-IN_W-FRAC){in_re[IN_W-1]}}, in_re, {FRAC{1'b0}},
                {(DW-IN_W-FRAC){in_im[IN_W-1]}}, in_im, {FRAC{1'b0}}};
    case (state)
      ST_IDLE: ram_we = in_valid;
      ST_RUN: begin
        ram_addr = bf_addr;
        ram_we   = (ph >= 4'd6);
        ram_wd   = {r_re[m_sel], r_im[m_sel]};
      end
      default: ram_addr = oc;
    endcase
  end

  fft4_ram #(.W(2*DW), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wd), .rdata(ram_q)
  );

  for (genvar m = 1; m < 4; m++) begin : g_tw
    logic [AW-1:0] e_m;
    logic signed [2*TW_W:0] mag;
    assign e_m = AW'(m) * tw_e;
    fft4_twiddle u_tw (.exp_i(e_m), .inv_i(inv_r), .w_re(w_re[m-1]), .w_im(w_im[m-1]));
    assign mag = $signed(w_re[m-1]) * $signed(w_re[m-1]) + $signed(w_im[m-1]) * $signed(w_im[m-1]);
    // table entries must lie on the unit circle (feeds R1/R2 accuracy)
    assert_twiddle_unit_R1: assert property (@(posedge clk) disable iff (rst)
      (state == ST_RUN) |-> (mag > 33'sd268304384 && mag < 33'sd268566528));
  end

  fft4_bfly #(.DW(DW)) u_bf (
    .x_re(a_re), .x_im(a_im), .w_re(w_re), .w_im(w_im), .inv_i(inv_r),
    .y_re(b_re), .y_im(b_im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; load_cnt <= '0; stg <= '0; bf <= '0; ph <= '0; oc <= '0; inv_r <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid) load_cnt <= load_cnt + 1'b1;
          if (start) begin
            state <= ST_RUN; inv_r <= inverse; load_cnt <= '0;
            stg <= '0; bf <= '0; ph <= '0;
          end
        end
        ST_RUN: begin
          if (ph == 4'd9) begin
            ph <= '0;
            bf <= bf + 1'b1;
            if (&bf) begin
              if (stg == SW'(LOG4N - 1)) begin state <= ST_OUT; oc <= '0; end
              else stg <= stg + 1'b1;
            end
          end else ph <= ph + 1'b1;
        end
        default: begin
          oc <= oc + 1'b1;
          if (&oc) state <= ST_IDLE;
        end
      endcase
    end
  end

  // operand capture (read latency 1) and butterfly result hold
  always_ff @(posedge clk) begin
    if (state == ST_RUN && ph >= 4'd1 && ph <= 4'd4) begin
      a_re[2'(ph - 4'd1)] <= ram_q[2*DW-1:DW];
      a_im[2'(ph - 4'd1)] <= ram_q[DW-1:0];
    end
    if (state == ST_RUN && ph == 4'd5) begin
      r_re <= b_re;
      r_im <= b_im;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; l1 <= 1'b0; l2 <= 1'b0; inv1 <= 1'b0;
      out_valid <= 1'b0; done <= 1'b0; out_re <= '0; out_im <= '0;
    end else begin
      v1        <= (state == ST_OUT);
      l1        <= (state == ST_OUT) && (&oc);
      inv1      <= inv_r;
      l2        <= l1;
      out_valid <= v1;
      done      <= l2;
      if (v1) begin
        out_re <= to_out(ram_q[2*DW-1:DW], inv1);
        out_im <= to_out(ram_q[DW-1:0], inv1);
      end
    end
  end

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_after_last_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(out_valid) && !out_valid));
  assert_burst_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |=> out_valid);
  assert_load_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && in_valid) |=> $stable(load_cnt));
  assert_mode_held_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && $past(state) == ST_RUN) |-> $stable(inv_r));
endmodule

// File: tb/fft4_engine_tb.sv
module fft4_engine_tb;
  localparam int N  = 64;
  localparam int IW = 4;
  localparam int OW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, start = 1'b0, inverse = 1'b0;
  logic signed [IW-1:0] in_re = '0, in_im = '0;
  logic out_valid, done;
  logic signed [OW-1:0] out_re, out_im;

  always #2 clk = ~clk;  // 4 ns period

  fft4_engine u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .start(start), .inverse(inverse), .out_valid(out_valid),
    .out_re(out_re), .out_im(out_im), .done(done)
  );

  int checks = 0, fails = 0;
  int q_re[$], q_im[$];
  int xr[N], xi[N];
  int tol = 1;
  int got_cnt = 0;
  bit done_seen = 0;
  bit prev_v = 0;
  string req = "R1";

  function automatic int iabs(int v); return (v < 0) ? -v : v; endfunction
  function automatic int clampo(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  // reference transform pushed into the scoreboard
  task automatic push_ref(bit inv);
    for (int k = 0; k < N; k++) begin
      real sr, si, a;
      sr = 0.0; si = 0.0;
      for (int n = 0; n < N; n++) begin
        a = (inv ? 1.0 : -1.0) * 2.0 * 3.14159265358979 * real'((n * k) % N) / real'(N);
        sr += real'(xr[n]) * $cos(a) - real'(xi[n]) * $sin(a);
        si += real'(xr[n]) * $sin(a) + real'(xi[n]) * $cos(a);
      end
      if (inv) begin sr = sr / 64.0; si = si / 64.0; end
      q_re.push_back(clampo(int'($floor(sr + 0.5))));
      q_im.push_back(clampo(int'($floor(si + 0.5))));
    end
  endtask

  // monitor: pop and compare each result, check the done pulse (R5)
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        checks++;
        if (q_re.size() == 0) begin
          fails++;
          $display("FAIL %s: unexpected result actual=%0d,%0d expected=none", req, out_re, out_im);
        end else begin
          int er, ei;
          er = q_re.pop_front(); ei = q_im.pop_front();
          if (iabs(int'(out_re) - er) > tol || iabs(int'(out_im) - ei) > tol) begin
            fails++;
            $display("FAIL %s: bin %0d actual=%0d,%0d expected=%0d,%0d", req, got_cnt,
                     out_re, out_im, er, ei);
          end
          got_cnt++;
        end
      end
      if (done) begin
        checks++;
        if (!(prev_v && !out_valid && got_cnt == N)) begin
          fails++;
          $display("FAIL R5: done timing actual prev_valid=%0d count=%0d expected prev_valid=1 count=%0d",
                   prev_v, got_cnt, N);
        end
        done_seen = 1;
      end
      prev_v = out_valid;
    end
  end

  task automatic run_frame(bit inv, bit disturb, int t, string r);
    tol = t; req = r; got_cnt = 0; done_seen = 0;
    push_ref(inv);
    for (int i = 0; i < N; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_re = IW'(xr[i]); in_im = IW'(xi[i]);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; start = 1'b1; inverse = inv;
    @(posedge clk); #1;
    start = 1'b0;
    if (disturb) begin
      // R6/R8: junk samples, starts and mode flips while computing
      for (int c = 0; c < 300; c++) begin
        @(posedge clk); #1;
        in_valid = 1'($urandom); start = 1'($urandom); inverse = 1'($urandom);
        in_re = IW'($urandom); in_im = IW'($urandom);
      end
      @(posedge clk); #1;
      in_valid = 1'b0; start = 1'b0; inverse = 1'b0;
    end
    for (int c = 0; c < 3000 && !done_seen; c++) @(posedge clk);
    @(negedge clk);
    checks++;
    if (!done_seen || q_re.size() != 0) begin
      fails++;
      $display("FAIL R5 (%s): frame end actual done=%0d left=%0d expected done=1 left=0",
               r, done_seen, q_re.size());
    end
    repeat (3) @(posedge clk);
  endtask

  task automatic fill_zero();
    for (int i = 0; i < N; i++) begin xr[i] = 0; xi[i] = 0; end
  endtask
  task automatic fill_const(int vr, int vi);
    for (int i = 0; i < N; i++) begin xr[i] = vr; xi[i] = vi; end
  endtask
  task automatic fill_rand();
    for (int i = 0; i < N; i++) begin
      xr[i] = int'($urandom_range(15)) - 8; xi[i] = int'($urandom_range(15)) - 8;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5: watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R7: quiet after reset with no start
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      checks++;
      if (out_valid || done) begin
        fails++;
        $display("FAIL R7: idle outputs actual valid=%0d done=%0d expected 0,0", out_valid, done);
      end
    end
    // R9/R3: impulse at x[0] gives a flat spectrum, exactly
    fill_zero(); xr[0] = 5; xi[0] = -3;
    run_frame(1'b0, 1'b0, 0, "R9");
    // R3/R1: impulse at x[1] checks sample ordering and twiddles
    fill_zero(); xr[1] = 7;
    run_frame(1'b0, 1'b0, 1, "R3");
    fill_zero(); xi[37] = -8; xr[50] = 6;
    run_frame(1'b0, 1'b0, 1, "R3");
    // R1: random frames
    for (int f = 0; f < 3; f++) begin
      fill_rand();
      run_frame(1'b0, 1'b0, 1, "R1");
    end
    // R4: clamping both ways
    fill_const(7, 7);
    run_frame(1'b0, 1'b0, 0, "R4");
    fill_const(-8, -8);
    run_frame(1'b0, 1'b0, 0, "R4");
    // R2: inverse
    fill_const(7, -8);
    run_frame(1'b1, 1'b0, 0, "R2");
    for (int f = 0; f < 2; f++) begin
      fill_rand();
      run_frame(1'b1, 1'b0, 1, "R2");
    end
    // R6/R8: disturbance during computation, both modes
    fill_rand();
    run_frame(1'b0, 1'b1, 1, "R6");
    fill_const(-8, 7);
    run_frame(1'b1, 1'b1, 0, "R8");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule